// File: doc/BRIEF.md
# Victim Buffer

This block is a small, fully associative store placed behind a direct-mapped first-level cache. Whenever that cache throws a line out to make room for a refill, the line is handed to this buffer instead of being lost. When the first-level cache later misses, it asks the buffer before going further down the memory hierarchy. All stored block addresses are compared against the request in the same cycle. A match returns the stored line so it can be exchanged back into the first-level cache. A mismatch sends a read request to the next memory level. The effect is that two blocks fighting over the same direct-mapped line bounce between the cache and this buffer rather than between the cache and slower memory.

The buffer is used only on the miss path, so it adds nothing to first-level hits. Each entry holds a full block address, the line data, a valid flag and a dirty flag. Entries are kept in insertion order, newest first. A new eviction into a full buffer removes the entry that was inserted longest ago. If that entry is dirty, the buffer issues a write-back downstream; if it is clean, the entry is discarded.

On a hit, the line the first-level cache displaces to make room for the returned line may be supplied with the lookup. That line takes over the slot of the entry that hit, including that entry's place in the insertion order.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is empty, `rsp_valid` and `dn_valid` are low, and the first lookup misses.
- R2: A line given on the eviction input can be found by a later lookup of the same block address. That lookup responds one cycle after it is presented with `rsp_hit`=1 and the stored data and dirty flag. At most one entry ever matches a lookup.
- R3: A lookup that matches no valid entry responds one cycle later with `rsp_hit`=0. In that same cycle the buffer issues a downstream read (`dn_valid`=1, `dn_write`=0) whose `dn_addr` equals the looked-up address.
- R4: A hit presented with `swap_valid`=1 stores the swap line in the slot that hit. Afterwards the swap address hits with the swap data and dirty flag, and the original address misses. A hit causes no downstream activity.
- R5: A hit presented with `swap_valid`=0 removes the entry. A later lookup of that address misses, and the freed slot absorbs the next eviction without pushing anything out.
- R6: An eviction into a buffer holding `ENTRIES` valid lines removes the entry inserted longest ago. All other lines remain retrievable.
- R7: A pushed-out entry that is dirty appears one cycle after the eviction as a downstream write (`dn_write`=1) carrying its address and data. A pushed-out clean entry produces no downstream activity. An eviction into a non-full buffer never produces downstream activity.
- R8: A swap line that replaces a hit entry inherits that entry's insertion age. If the hit entry was the oldest, the swap line is the next one pushed out.
- R9: When a lookup and an eviction are presented in the same cycle, the lookup is served and the eviction is ignored. A later lookup of the ignored address misses.
- R10: Each lookup gets exactly one response, in the cycle after it is presented. `rsp_valid` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evict_valid | input | 1 | A line discarded by the first-level cache is offered |
| evict_addr | input | ADDR_W | Block address of the discarded line |
| evict_data | input | DATA_W | Data of the discarded line |
| evict_dirty | input | 1 | Discarded line holds modified data |
| lkp_valid | input | 1 | Lookup after a first-level miss |
| lkp_addr | input | ADDR_W | Block address being looked up |
| swap_valid | input | 1 | A displaced first-level line accompanies the lookup |
| swap_addr | input | ADDR_W | Block address of the displaced line |
| swap_data | input | DATA_W | Data of the displaced line |
| swap_dirty | input | 1 | Displaced line holds modified data |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup found a matching entry |
| rsp_data | output | DATA_W | Data of the matching entry (zero on a miss) |
| rsp_dirty | output | 1 | Dirty flag of the matching entry |
| dn_valid | output | 1 | Downstream request valid |
| dn_write | output | 1 | 1 = write-back of a pushed-out dirty line, 0 = read after a miss |
| dn_addr | output | ADDR_W | Downstream block address |
| dn_data | output | DATA_W | Write-back data (zero for reads) |

## Verification
The hardest state to reach from the ports is a swapped-in line that sits at the oldest position of a full buffer. Reaching it needs a full buffer, a hit on exactly its oldest entry, and then one more eviction to expose whether the swap line inherited that age. The stimulus fills all slots with alternately dirty and clean lines, pushes out a few to move the age boundary, and then hits the oldest remaining address with a dirty swap line. The next eviction must produce a write-back of the swap data. A reference queue in the bench tracks insertion order, so every later push-out, write-back and miss is predicted without looking inside the design.

// File: rtl/vb_pkg.sv
package vb_pkg;

    // Operation applied to the entry store in a given cycle.
    typedef enum logic [1:0] {
        VB_IDLE = 2'd0,
        VB_PUSH = 2'd1,   // insert newest line at slot 0, age everything by one
        VB_SWAP = 2'd2,   // overwrite the hit slot in place
        VB_DROP = 2'd3    // remove the hit slot and close the gap
    } vb_op_e;

endpackage

// File: rtl/vb_cam.sv
module vb_cam #(
    parameter int N  = 8,
    parameter int AW = 26,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [AW-1:0] key,
    input  logic [N-1:0]  ent_valid,
    input  logic [AW-1:0] ent_addr [N],
    output logic [N-1:0]  hit_vec,
    output logic          hit,
    output logic [IW-1:0] hit_idx
);

    // One comparator per entry, all evaluated in parallel.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g] && (ent_addr[g] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                hit_idx = IW'(i);
            end
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/vb_queue.sv
module vb_queue
    import vb_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 26,
    parameter int DW = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  vb_op_e        op,
    input  logic [IW-1:0] idx,
    input  logic [AW-1:0] new_addr,
    input  logic [DW-1:0] new_data,
    input  logic          new_dirty,
    output logic [N-1:0]  ent_valid,
    output logic [N-1:0]  ent_dirty,
    output logic [AW-1:0] ent_addr [N],
    output logic [DW-1:0] ent_data [N]
);

    // Slot 0 holds the newest line, slot N-1 the oldest. Valid lines are
    // always packed towards slot 0, so slot N-1 is valid only when full.
    typedef struct packed {
        logic [N-1:0]         v;
        logic [N-1:0]         dty;
        logic [N-1:0][AW-1:0] a;
        logic [N-1:0][DW-1:0] d;
    } q_state_t;

    q_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (op)
            VB_PUSH: begin
                for (int i = N - 1; i > 0; i--) begin
                    s_d.v[i]   = s_q.v[i-1];
                    s_d.dty[i] = s_q.dty[i-1];
                    s_d.a[i]   = s_q.a[i-1];
                    s_d.d[i]   = s_q.d[i-1];
                end
                s_d.v[0]   = 1'b1;
                s_d.dty[0] = new_dirty;
                s_d.a[0]   = new_addr;
                s_d.d[0]   = new_data;
            end
            VB_SWAP: begin
                s_d.v[idx]   = 1'b1;
                s_d.dty[idx] = new_dirty;
                s_d.a[idx]   = new_addr;
                s_d.d[idx]   = new_data;
            end
            VB_DROP: begin
                for (int i = 0; i < N; i++) begin
                    if (i >= int'(idx)) begin
                        if (i < N - 1) begin
                            s_d.v[i]   = s_q.v[(i < N - 1) ? i + 1 : i];
                            s_d.dty[i] = s_q.dty[(i < N - 1) ? i + 1 : i];
                            s_d.a[i]   = s_q.a[(i < N - 1) ? i + 1 : i];
                            s_d.d[i]   = s_q.d[(i < N - 1) ? i + 1 : i];
                        end else begin
                            s_d.v[i]   = 1'b0;
                            s_d.dty[i] = 1'b0;
                            s_d.a[i]   = '0;
                            s_d.d[i]   = '0;
                        end
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ent_valid = s_q.v;
    assign ent_dirty = s_q.dty;
    for (genvar g = 0; g < N; g++) begin : g_out
        assign ent_addr[g] = s_q.a[g];
        assign ent_data[g] = s_q.d[g];
    end

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import vb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 64,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [DATA_W-1:0] evict_data,
    input  logic              evict_dirty,
    input  logic              lkp_valid,
    input  logic [ADDR_W-1:0] lkp_addr,
    input  logic              swap_valid,
    input  logic [ADDR_W-1:0] swap_addr,
    input  logic [DATA_W-1:0] swap_data,
    input  logic              swap_dirty,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_dirty,
    output logic              dn_valid,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_data
);

    // Registered outputs, rebuilt from scratch every cycle (all pulses).
    typedef struct packed {
        logic              rsp_v;
        logic              rsp_hit;
        logic [DATA_W-1:0] rsp_data;
        logic              rsp_dirty;
        logic              dn_v;
        logic              dn_w;
        logic [ADDR_W-1:0] dn_addr;
        logic [DATA_W-1:0] dn_data;
    } out_t;

    out_t out_d, out_q;

    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_dirty;
    logic [ADDR_W-1:0]  ent_addr [ENTRIES];
    logic [DATA_W-1:0]  ent_data [ENTRIES];

    logic [ENTRIES-1:0] cam_hit_vec;
    logic               cam_hit;
    logic [IDX_W-1:0]   cam_idx;

    vb_op_e             q_op;
    logic [IDX_W-1:0]   q_idx;
    logic [ADDR_W-1:0]  q_addr;
    logic [DATA_W-1:0]  q_data;
    logic               q_dirty;

    vb_cam #(
        .N  (ENTRIES),
        .AW (ADDR_W)
    ) u_cam (
        .key       (lkp_addr),
        .ent_valid (ent_valid),
        .ent_addr  (ent_addr),
        .hit_vec   (cam_hit_vec),
        .hit       (cam_hit),
        .hit_idx   (cam_idx)
    );

    vb_queue #(
        .N  (ENTRIES),
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (q_op),
        .idx       (q_idx),
        .new_addr  (q_addr),
        .new_data  (q_data),
        .new_dirty (q_dirty),
        .ent_valid (ent_valid),
        .ent_dirty (ent_dirty),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data)
    );

    // Lookups take priority; an eviction in the same cycle is discarded.
    always_comb begin
        out_d   = '0;
        q_op    = VB_IDLE;
        q_idx   = cam_idx;
        q_addr  = evict_addr;
        q_data  = evict_data;
        q_dirty = evict_dirty;

        if (lkp_valid) begin
            out_d.rsp_v = 1'b1;
            if (cam_hit) begin
                out_d.rsp_hit   = 1'b1;
                out_d.rsp_data  = ent_data[cam_idx];
                out_d.rsp_dirty = ent_dirty[cam_idx];
                if (swap_valid) begin
                    q_op    = VB_SWAP;
                    q_addr  = swap_addr;
                    q_data  = swap_data;
                    q_dirty = swap_dirty;
                end else begin
                    q_op = VB_DROP;
                end
            end else begin
                out_d.dn_v    = 1'b1;
                out_d.dn_w    = 1'b0;
                out_d.dn_addr = lkp_addr;
            end
        end else if (evict_valid) begin
            q_op = VB_PUSH;
            // Oldest slot is occupied only when the buffer is full.
            if (ent_valid[ENTRIES-1] && ent_dirty[ENTRIES-1]) begin
                out_d.dn_v    = 1'b1;
                out_d.dn_w    = 1'b1;
                out_d.dn_addr = ent_addr[ENTRIES-1];
                out_d.dn_data = ent_data[ENTRIES-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rsp_valid = out_q.rsp_v;
    assign rsp_hit   = out_q.rsp_hit;
    assign rsp_data  = out_q.rsp_data;
    assign rsp_dirty = out_q.rsp_dirty;
    assign dn_valid  = out_q.dn_v;
    assign dn_write  = out_q.dn_w;
    assign dn_addr   = out_q.dn_addr;
    assign dn_data   = out_q.dn_data;

endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
    parameter int N  = 8,
    parameter int AW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lkp_valid,
    input logic [AW-1:0] lkp_addr,
    input logic          evict_valid,
    input logic          rsp_valid,
    input logic          rsp_hit,
    input logic          dn_valid,
    input logic          dn_write,
    input logic [AW-1:0] dn_addr,
    input logic [N-1:0]  hit_vec
);

    assert_rsp_after_lookup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> rsp_valid);

    assert_no_stray_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lkp_valid));

    assert_read_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (dn_valid && !dn_write));

    assert_read_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_write) |-> (rsp_valid && !rsp_hit && dn_addr == $past(lkp_addr)));

    assert_quiet_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !dn_valid);

    assert_wb_after_evict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_write) |-> $past(evict_valid && !lkp_valid));

    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

bind victim_buffer vb_checker #(
    .N  (ENTRIES),
    .AW (ADDR_W)
) u_vb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lkp_valid   (lkp_valid),
    .lkp_addr    (lkp_addr),
    .evict_valid (evict_valid),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .dn_valid    (dn_valid),
    .dn_write    (dn_write),
    .dn_addr     (dn_addr),
    .hit_vec     (cam_hit_vec)
);

// File: tb/victim_buffer_test.sv
module victim_buffer_test;

    localparam int N  = 8;
    localparam int AW = 26;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evict_valid, evict_dirty, lkp_valid, swap_valid, swap_dirty;
    logic [AW-1:0] evict_addr, lkp_addr, swap_addr;
    logic [DW-1:0] evict_data, swap_data;
    logic          rsp_valid, rsp_hit, rsp_dirty, dn_valid, dn_write;
    logic [DW-1:0] rsp_data, dn_data;
    logic [AW-1:0] dn_addr;

    victim_buffer uut (
        .clk(clk), .rst_n(rst_n),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .evict_data(evict_data), .evict_dirty(evict_dirty),
        .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
        .swap_valid(swap_valid), .swap_addr(swap_addr),
        .swap_data(swap_data), .swap_dirty(swap_dirty),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
        .dn_valid(dn_valid), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_data(dn_data)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int            due;
        bit            rv, rhit, rdirty, dv, dw;
        logic [DW-1:0] rdata, ddata;
        logic [AW-1:0] daddr;
        string         tag;
    } exp_t;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        bit            dirty;
    } line_t;

    exp_t  exp_q[$];
    line_t mdl[$];   // index 0 newest

    function automatic void chk(bit ok, string tag, string what,
                                logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endfunction

    function automatic exp_t blank(int due, string tag);
        exp_t e;
        e.due = due; e.rv = 0; e.rhit = 0; e.rdirty = 0; e.dv = 0; e.dw = 0;
        e.rdata = '0; e.ddata = '0; e.daddr = '0; e.tag = tag;
        return e;
    endfunction

    task automatic idle_inputs();
        evict_valid = 0; evict_addr = '0; evict_data = '0; evict_dirty = 0;
        lkp_valid = 0; lkp_addr = '0;
        swap_valid = 0; swap_addr = '0; swap_data = '0; swap_dirty = 0;
    endtask

    task automatic evict(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit dty, input string tag);
        exp_t  e;
        line_t ln, old;
        @(negedge clk);
        evict_valid = 1; evict_addr = a; evict_data = d; evict_dirty = dty;
        e = blank(cyc + 1, tag);
        if (mdl.size() == N) begin
            old = mdl.pop_back();
            if (old.dirty) begin
                e.dv = 1; e.dw = 1; e.daddr = old.a; e.ddata = old.d;
            end
        end
        ln.a = a; ln.d = d; ln.dirty = dty;
        mdl.push_front(ln);
        if (e.dv) exp_q.push_back(e);
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic lookup_core(input logic [AW-1:0] a, input bit sv,
                               input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                               input bit sdty, input bit ev, input logic [AW-1:0] ea,
                               input string tag);
        exp_t  e;
        line_t sw;
        int    k;
        @(negedge clk);
        lkp_valid = 1; lkp_addr = a;
        swap_valid = sv; swap_addr = sa; swap_data = sd; swap_dirty = sdty;
        if (ev) begin
            evict_valid = 1; evict_addr = ea; evict_data = 64'hBAD; evict_dirty = 1;
        end
        e = blank(cyc + 1, tag);
        e.rv = 1;
        k = -1;
        foreach (mdl[i]) if (mdl[i].a == a) k = i;
        if (k >= 0) begin
            e.rhit = 1; e.rdata = mdl[k].d; e.rdirty = mdl[k].dirty;
            if (sv) begin
                sw.a = sa; sw.d = sd; sw.dirty = sdty;
                mdl[k] = sw;
            end else begin
                mdl.delete(k);
            end
        end else begin
            e.dv = 1; e.dw = 0; e.daddr = a;
        end
        exp_q.push_back(e);
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic lookup(input logic [AW-1:0] a, input string tag);
        lookup_core(a, 0, '0, '0, 0, 0, '0, tag);
    endtask

    task automatic lookup_swap(input logic [AW-1:0] a, input logic [AW-1:0] sa,
                               input logic [DW-1:0] sd, input bit sdty, input string tag);
        lookup_core(a, 1, sa, sd, sdty, 0, '0, tag);
    endtask

    // Scoreboard monitor: every cycle is either an expected event or idle.
    always @(negedge clk) begin : monitor
        exp_t e;
        if (rst_n) begin
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                e = exp_q.pop_front();
                chk(rsp_valid == e.rv, e.tag, "rsp_valid", 64'(rsp_valid), 64'(e.rv));
                if (e.rv) begin
                    chk(rsp_hit == e.rhit, e.tag, "rsp_hit", 64'(rsp_hit), 64'(e.rhit));
                    if (e.rhit) begin
                        chk(rsp_data == e.rdata, e.tag, "rsp_data", rsp_data, e.rdata);
                        chk(rsp_dirty == e.rdirty, e.tag, "rsp_dirty", 64'(rsp_dirty), 64'(e.rdirty));
                    end
                end
                chk(dn_valid == e.dv, e.tag, "dn_valid", 64'(dn_valid), 64'(e.dv));
                if (e.dv) begin
                    chk(dn_write == e.dw, e.tag, "dn_write", 64'(dn_write), 64'(e.dw));
                    chk(dn_addr == e.daddr, e.tag, "dn_addr", 64'(dn_addr), 64'(e.daddr));
                    if (e.dw) chk(dn_data == e.ddata, e.tag, "dn_data", dn_data, e.ddata);
                end
            end else begin
                chk(rsp_valid == 0, "R10", "unexpected rsp_valid", 64'(rsp_valid), 64'd0);
                chk(dn_valid == 0, "R7", "unexpected dn_valid", 64'(dn_valid), 64'd0);
            end
        end
    end

    initial begin : watchdog
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    function automatic logic [AW-1:0] ad(int i);
        return AW'(26'h0040_000 + i * 26'h100);
    endfunction

    function automatic logic [DW-1:0] dt(int i);
        return 64'hC0DE_0000_0000_0000 | 64'(i * 64'h1_0001);
    endfunction

    initial begin : stim
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state of outputs
        chk(rsp_valid == 0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(dn_valid == 0, "R1", "dn_valid after reset", 64'(dn_valid), 64'd0);
        rst_n = 1;
        lookup(ad(99), "R1");

        // R2, R5: store, find, drop
        evict(ad(1), dt(1), 1, "R2");
        evict(ad(2), dt(2), 0, "R2");
        lookup(ad(1), "R2");
        lookup(ad(1), "R5");
        lookup(ad(3), "R3");
        // R4: swap on hit
        lookup_swap(ad(2), ad(20), dt(20), 1, "R4");
        lookup(ad(2), "R4");
        lookup_swap(ad(20), ad(21), dt(21), 0, "R4");
        lookup(ad(21), "R5");
        lookup(ad(20), "R4");

        // R6, R7: fill to capacity with alternating dirty lines, then overflow
        for (int i = 0; i < N; i++) evict(ad(100 + i), dt(100 + i), (i % 2) == 0, "R7");
        evict(ad(200), dt(200), 0, "R7");   // oldest dirty pushed out
        evict(ad(201), dt(201), 1, "R7");   // oldest clean dropped silently
        lookup(ad(100), "R6");
        lookup(ad(101), "R6");
        // R8: hit the oldest entry with a dirty swap line, then overflow
        lookup_swap(ad(102), ad(300), dt(300), 1, "R8");
        evict(ad(202), dt(202), 0, "R8");
        lookup(ad(300), "R8");
        lookup(ad(103), "R6");
        // R5: freed slot absorbs next eviction without push-out
        lookup(ad(104), "R5");
        evict(ad(203), dt(203), 1, "R5");
        lookup(ad(105), "R6");
        evict(ad(204), dt(204), 0, "R6");

        // R9: lookup and eviction together
        lookup_core(ad(400), 0, '0, '0, 0, 1, ad(401), "R9");
        lookup(ad(401), "R9");
        lookup(ad(200), "R2");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10", "outstanding expected events", 64'(exp_q.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule